// File: doc/BRIEF.md
# Period Timer with Per-Source Interrupt Flag Clearing

A 16-bit timer/counter for a microcontroller-style peripheral bus. A selectable prescaler feeds a counter that runs between zero and a programmable period, either upward or downward. One channel compares against the count or captures it on an external trigger. Two interrupt flags, overflow and channel, drive one level-type interrupt request through per-source enable bits.

Each flag has its own clearing rule, and this rule sets how the block is used. The overflow flag is never cleared by the interrupt controller's vector acknowledge. An overflow handler must clear it explicitly, with a write-one to the flag register or as a side effect of a write on the DMA port. If it does not, the request stays high and the handler runs again at once. The channel flag clears on vector acknowledge in compare mode. In capture mode it clears when the captured value is read.

Register map (3-bit address): 0 = CTRL, 1 = INTEN, 2 = FLAGS, 3 = CNT, 4 = PER, 5 = CHAN. Reads are combinational on `reg_rdata`. Writes and read side effects take place at the rising clock edge.

Top module: `ptimer`

## Requirements
- R1: After reset, every register reads zero, both flags are clear, `irq` is low, and the counter holds still.
- R2: CTRL[2:0] selects the count rate. 0 stops the counter. 1, 2, 3, 4, 5, 6 and 7 give one tick every 1, 2, 4, 8, 64, 256 and 1024 clocks.
- R3: With CTRL[3]=0 the counter counts up from 0 to PER inclusive, then wraps to 0 and sets the overflow flag (FLAGS bit 0). One period is (PER+1) times the division factor in clocks.
- R4: With CTRL[3]=1 the counter counts down. On a tick at 0 it reloads PER and sets the overflow flag.
- R5: Writing FLAGS clears each flag whose bit is 1 in the write data. A bit written as 0 leaves its flag unchanged.
- R6: A pulse on `ack_ovf` does not change the overflow flag.
- R7: In compare mode (CTRL[4]=0), a tick while CNT equals CHAN sets the channel flag (FLAGS bit 1). A pulse on `ack_cmp` clears it.
- R8: In capture mode (CTRL[4]=1), a `cap_trig` pulse copies CNT into CHAN and sets the channel flag. A register read of CHAN clears the flag. `ack_cmp` has no effect on it.
- R9: A `dma_wr` pulse loads the counter (`dma_sel`=0) or the period (`dma_sel`=1) and clears the overflow flag.
- R10: If a flag's set event and its clear fall in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when some flag is set and its INTEN bit is 1 (bit 0 overflow, bit 1 channel), and it holds as a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| dma_wr | input | 1 | DMA-port write strobe |
| dma_sel | input | 1 | DMA target: 0 counter, 1 period |
| dma_wdata | input | 16 | DMA-port write data |
| ack_ovf | input | 1 | Overflow vector acknowledge |
| ack_cmp | input | 1 | Channel vector acknowledge |
| cap_trig | input | 1 | Capture trigger pulse |
| irq | output | 1 | Level interrupt request |

## Verification
Flag and register results appear one edge after their cause. A flag set by a tick at edge k can be read just after edge k. A register write, acknowledge, DMA write or capture takes effect at the edge that samples it. A tick caused by a new CTRL value starts one edge after the write. The bench drives each stimulus at a falling edge and samples at the next falling edge. For counting sequences it counts edges one by one. Periods are measured as the edge count between two successive rising edges of `irq`, so the prescaler phase drops out.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int PRE_W = 10;
  localparam int AW    = 3;
  localparam int NFLAG = 2;

  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_INTEN = 3'd1;
  localparam logic [AW-1:0] A_FLAGS = 3'd2;
  localparam logic [AW-1:0] A_CNT   = 3'd3;
  localparam logic [AW-1:0] A_PER   = 3'd4;
  localparam logic [AW-1:0] A_CHAN  = 3'd5;

  localparam int F_OVF = 0;
  localparam int F_CH  = 1;

  // Low-bit mask of the free-running prescaler that marks a tick
  function automatic logic [PRE_W-1:0] tick_mask(input logic [2:0] sel);
    case (sel)
      3'd2:    tick_mask = PRE_W'(1);
      3'd3:    tick_mask = PRE_W'(3);
      3'd4:    tick_mask = PRE_W'(7);
      3'd5:    tick_mask = PRE_W'(63);
      3'd6:    tick_mask = PRE_W'(255);
      3'd7:    tick_mask = PRE_W'(1023);
      default: tick_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/ptimer_prescale.sv
module ptimer_prescale
  import ptimer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    mask = tick_mask(sel);
    tick = (sel != 3'd0) && ((pre_q & mask) == mask);
  end

  AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0) |-> !tick); // R2
endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         down,
  input  logic [W-1:0] per,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap_evt
);
  function automatic logic at_end(input logic dn, input logic [W-1:0] c,
                                  input logic [W-1:0] p);
    at_end = dn ? (c == '0) : (c >= p);
  endfunction

  function automatic logic [W-1:0] step(input logic dn, input logic [W-1:0] c,
                                        input logic [W-1:0] p);
    if (at_end(dn, c, p)) step = dn ? p : '0;
    else                  step = dn ? c - 1'b1 : c + 1'b1;
  endfunction

  logic end_hit;
  assign end_hit  = at_end(down, cnt, per);
  assign wrap_evt = tick && !ld_en && end_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (ld_en) cnt <= ld_val;
    else if (tick)  cnt <= step(down, cnt, per);
  end

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down && !ld_en && cnt == per) |=> (cnt == '0)); // R3
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down && !ld_en && cnt == '0) |=> (cnt == $past(per))); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_en) |=> $stable(cnt)); // R2
endmodule

// File: rtl/ptimer_flags.sv
module ptimer_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= set_ev[i] | (flags[i] & ~clr_ev[i]);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags[i]); // R10
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ev[i] && !set_ev[i]) |=> !flags[i]); // R5
  end
endmodule

// File: rtl/ptimer.sv
module ptimer
  import ptimer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          dma_wr,
  input  logic          dma_sel,
  input  logic [W-1:0]  dma_wdata,
  input  logic          ack_ovf,
  input  logic          ack_cmp,
  input  logic          cap_trig,
  output logic          irq
);
  localparam int CTRL_W = 5;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NFLAG-1:0]  inten_q;
  logic [W-1:0]      per_q;
  logic [W-1:0]      chan_q;
  logic [W-1:0]      cnt;
  logic [NFLAG-1:0]  flags;

  logic tick, wrap_evt, down, cap_mode;
  logic wr_ctrl, wr_inten, wr_flags, wr_cnt, wr_per, wr_chan, rd_chan;
  logic cnt_ld;
  logic [W-1:0] cnt_ld_val;
  logic cmp_evt, cap_evt;
  logic ovf_set_s, ovf_clr_s, ch_set_s, ch_clr_s;

  assign down     = ctrl_q[3];
  assign cap_mode = ctrl_q[4];

  assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  assign wr_inten = reg_wr && reg_addr == A_INTEN;
  assign wr_flags = reg_wr && reg_addr == A_FLAGS;
  assign wr_cnt   = reg_wr && reg_addr == A_CNT;
  assign wr_per   = reg_wr && reg_addr == A_PER;
  assign wr_chan  = reg_wr && reg_addr == A_CHAN;
  assign rd_chan  = reg_rd && reg_addr == A_CHAN;

  ptimer_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (ctrl_q[2:0]),
    .tick (tick)
  );

  assign cnt_ld     = wr_cnt || (dma_wr && !dma_sel);
  assign cnt_ld_val = wr_cnt ? reg_wdata : dma_wdata;

  ptimer_count #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .down    (down),
    .per     (per_q),
    .ld_en   (cnt_ld),
    .ld_val  (cnt_ld_val),
    .cnt     (cnt),
    .wrap_evt(wrap_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      inten_q <= '0;
      per_q   <= '0;
      chan_q  <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= reg_wdata[CTRL_W-1:0];
      if (wr_inten) inten_q <= reg_wdata[NFLAG-1:0];
      if (wr_per)                 per_q <= reg_wdata;
      else if (dma_wr && dma_sel) per_q <= dma_wdata;
      if (cap_evt)      chan_q <= cnt;
      else if (wr_chan) chan_q <= reg_wdata;
    end
  end

  assign cmp_evt = !cap_mode && tick && (cnt == chan_q);
  assign cap_evt = cap_mode && cap_trig;

  assign ovf_set_s = wrap_evt;
  assign ovf_clr_s = (wr_flags && reg_wdata[F_OVF]) || dma_wr;
  assign ch_set_s  = cmp_evt || cap_evt;
  assign ch_clr_s  = (wr_flags && reg_wdata[F_CH]) ||
                     (!cap_mode && ack_cmp) || (cap_mode && rd_chan);

  ptimer_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_ev({ch_set_s, ovf_set_s}),
    .clr_ev({ch_clr_s, ovf_clr_s}),
    .flags (flags)
  );

  assign irq = |(flags & inten_q);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = W'(ctrl_q);
      A_INTEN: reg_rdata = W'(inten_q);
      A_FLAGS: reg_rdata = W'(flags);
      A_CNT:   reg_rdata = cnt;
      A_PER:   reg_rdata = per_q;
      A_CHAN:  reg_rdata = chan_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_OVF_ACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_OVF] && ack_ovf && !ovf_clr_s) |=> flags[F_OVF]); // R6
  AST_CMP_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && ack_cmp && !ch_set_s) |=> !flags[F_CH]); // R7
  AST_CAP_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && rd_chan && !ch_set_s) |=> !flags[F_CH]); // R8
  AST_CAP_ACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && flags[F_CH] && ack_cmp && !rd_chan && !wr_flags && !wr_ctrl)
      |=> flags[F_CH]); // R8
  AST_DMA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr && !wrap_evt) |=> !flags[F_OVF]); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (inten_q == '0) |-> !irq); // R11
endmodule

// File: tb/ptimer_bench.sv
`timescale 1ns/1ps
module ptimer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dma_wr = 1'b0, dma_sel = 1'b0;
  logic [15:0] dma_wdata = '0;
  logic        ack_ovf = 1'b0, ack_cmp = 1'b0, cap_trig = 1'b0;
  logic        irq;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  ptimer u_ptimer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_wr(dma_wr), .dma_sel(dma_sel), .dma_wdata(dma_wdata),
    .ack_ovf(ack_ovf), .ack_cmp(ack_cmp), .cap_trig(cap_trig), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // {clksel[2:0], per[15:0], expected period in clocks[15:0]}
  localparam int NV = 7;
  localparam logic [34:0] VEC [NV] = '{
    {3'd1, 16'd3, 16'd4},
    {3'd2, 16'd4, 16'd10},
    {3'd3, 16'd2, 16'd12},
    {3'd4, 16'd0, 16'd8},
    {3'd5, 16'd1, 16'd128},
    {3'd6, 16'd3, 16'd1024},
    {3'd7, 16'd1, 16'd2048}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output int t);
    int n = 0;
    while (!irq && n < 5000) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
    t = cyc;
  endtask

  // Leaves the counter stopped at 0 with the overflow flag set
  task automatic make_ovf();
    wr(3'd0, 16'd0);
    wr(3'd4, 16'd2);
    wr(3'd3, 16'd2);
    wr(3'd0, 16'd1);
    wr(3'd0, 16'd0);
  endtask

  logic [15:0] v;
  int t1, t2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    peek(3'd2, v); check(v == 0, "R1 flags", v, 0);
    peek(3'd0, v); check(v == 0, "R1 ctrl", v, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    repeat (5) @(negedge clk);
    peek(3'd3, v); check(v == 0, "R1 counter still", v, 0);

    // R2 R3: period table
    wr(3'd1, 16'd1);
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 16'd0);
      wr(3'd4, VEC[i][31:16]);
      wr(3'd3, 16'd0);
      wr(3'd2, 16'd3);
      wr(3'd0, {13'd0, VEC[i][34:32]});
      wait_irq(t1);
      wr(3'd2, 16'd1);
      wait_irq(t2);
      check((t2 - t1) == int'(VEC[i][15:0]), "R2 R3 period", t2 - t1, int'(VEC[i][15:0]));
    end
    wr(3'd1, 16'd0);

    // R2: clock off holds counter
    wr(3'd0, 16'd0);
    wr(3'd3, 16'd7);
    repeat (20) @(negedge clk);
    peek(3'd3, v); check(v == 7, "R2 clock off", v, 7);

    // R3 R5 R6 R11
    wr(3'd2, 16'd3);
    make_ovf();
    peek(3'd2, v); check(v[0] == 1'b1, "R3 ovf set at TOP", v[0], 1);
    wr(3'd2, 16'd0);
    peek(3'd2, v); check(v[0] == 1'b1, "R5 write zero keeps", v[0], 1);
    wr(3'd2, 16'd2);
    peek(3'd2, v); check(v[0] == 1'b1, "R5 other bit keeps", v[0], 1);
    wr(3'd1, 16'd1);
    ack_ovf = 1'b1; @(posedge clk); @(negedge clk); ack_ovf = 1'b0;
    peek(3'd2, v); check(v[0] == 1'b1, "R6 ack keeps ovf", v[0], 1);
    check(irq == 1'b1, "R11 irq level", irq, 1);
    wr(3'd1, 16'd0);
    check(irq == 1'b0, "R11 irq masked", irq, 0);
    wr(3'd2, 16'd1);
    peek(3'd2, v); check(v[0] == 1'b0, "R5 write one clears", v[0], 0);

    // R9: DMA writes
    make_ovf();
    dma_wr = 1'b1; dma_sel = 1'b0; dma_wdata = 16'd9;
    @(posedge clk); @(negedge clk); dma_wr = 1'b0;
    peek(3'd2, v); check(v[0] == 1'b0, "R9 dma cnt clears ovf", v[0], 0);
    peek(3'd3, v); check(v == 9, "R9 dma cnt load", v, 9);
    make_ovf();
    dma_wr = 1'b1; dma_sel = 1'b1; dma_wdata = 16'd50;
    @(posedge clk); @(negedge clk); dma_wr = 1'b0;
    peek(3'd2, v); check(v[0] == 1'b0, "R9 dma per clears ovf", v[0], 0);
    peek(3'd4, v); check(v == 50, "R9 dma per load", v, 50);

    // R10: set and clear in the same cycle
    wr(3'd4, 16'd2);
    wr(3'd3, 16'd2);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'd1);
    wr(3'd2, 16'd1);
    wr(3'd0, 16'd0);
    peek(3'd2, v); check(v[0] == 1'b1, "R10 set wins", v[0], 1);

    // R4: down counting
    wr(3'd2, 16'd3);
    wr(3'd4, 16'd6);
    wr(3'd3, 16'd3);
    wr(3'd0, 16'd9);
    repeat (3) @(posedge clk);
    @(negedge clk);
    peek(3'd2, v); check(v[0] == 1'b0, "R4 no ovf before BOTTOM", v[0], 0);
    peek(3'd3, v); check(v == 0, "R4 reached zero", v, 0);
    @(posedge clk); @(negedge clk);
    peek(3'd2, v); check(v[0] == 1'b1, "R4 ovf at BOTTOM", v[0], 1);
    peek(3'd3, v); check(v == 6, "R4 reload PER", v, 6);
    wr(3'd0, 16'd0);

    // R7: compare and vector acknowledge
    wr(3'd4, 16'd100);
    wr(3'd5, 16'd5);
    wr(3'd3, 16'd4);
    wr(3'd2, 16'd3);
    wr(3'd1, 16'd2);
    wr(3'd0, 16'd1);
    @(posedge clk); @(negedge clk);
    peek(3'd2, v); check(v[1] == 1'b0, "R7 no match yet", v[1], 0);
    @(posedge clk); @(negedge clk);
    peek(3'd2, v); check(v[1] == 1'b1, "R7 match sets", v[1], 1);
    check(irq == 1'b1, "R11 channel irq", irq, 1);
    ack_cmp = 1'b1; @(posedge clk); @(negedge clk); ack_cmp = 1'b0;
    peek(3'd2, v); check(v[1] == 1'b0, "R7 ack clears", v[1], 0);
    check(irq == 1'b0, "R11 irq drops", irq, 0);
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd0);

    // R8: capture
    wr(3'd0, 16'd16);
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd42);
    cap_trig = 1'b1; @(posedge clk); @(negedge clk); cap_trig = 1'b0;
    peek(3'd5, v); check(v == 42, "R8 captured value", v, 42);
    peek(3'd2, v); check(v[1] == 1'b1, "R8 capture sets", v[1], 1);
    ack_cmp = 1'b1; @(posedge clk); @(negedge clk); ack_cmp = 1'b0;
    peek(3'd2, v); check(v[1] == 1'b1, "R8 ack keeps", v[1], 1);
    rd(3'd5, v); check(v == 42, "R8 read value", v, 42);
    peek(3'd2, v); check(v[1] == 1'b0, "R8 read clears", v[1], 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule